// File: doc/BRIEF.md
# DMA Controller with Bus Handover

This block is a single-master DMA engine. It copies a block of words from a peripheral data port into a memory write port over a shared bus. Software first loads a start address and a word count. It then writes a control word that sets the bus-holding mode and the enabled peripheral channels, and that starts the job.

Each job runs through four phases, always in the same order:

1. It waits for a peripheral request on an enabled channel.
2. It requests the bus and waits for the grant.
3. It moves the words.
4. It releases the bus, pulses an end strobe to the peripheral that was served, and raises a sticky interrupt.

In burst mode the bus is held from the first word to the last word of the block. In cycle-steal mode the bus is requested again for every word and handed back after that word. Software acknowledges the interrupt by writing the clear register.

Top module: `dma_bus_handover`

## Requirements
- R1: After reset, `busy`, `bus_req`, `mem_we`, `per_ack`, `per_end` and `irq` are all low.
- R2: Only channels whose enable bit is set (control bit 8+n for channel n) can start a bus request. Among the enabled channels that are requesting, the lowest index wins. `per_ack` is one-hot on the served channel for each word moved.
- R3: `bus_req` stays high until `bus_gnt` arrives. `mem_we` is never high while `bus_gnt` is low.
- R4: Software writes go through `cfg_sel`: 0 loads the start address, 1 loads the word count, 2 loads the control word (bit 0 starts the job, bit 1 selects burst) and 3 clears the interrupt. Writes with `cfg_sel` 0 to 2 are ignored while `busy` is high.
- R5: One cycle after the last word, `per_end` pulses for one cycle on the served channel. In the cycle after that pulse, `irq` is high and `busy` is low.
- R6: In burst mode, `bus_req` rises once per job and stays high until the last word has moved.
- R7: Word i of a job is written to start address + i with the peripheral data present in that cycle. The count drops by one per word.
- R8: A start with a count of zero sets `irq` in the next cycle and never raises `bus_req`.
- R9: `irq` stays high until a write with `cfg_sel` = 3.
- R10: In cycle-steal mode, `bus_req` drops after every word, so it rises once per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| per_req | input | NCH | Peripheral request lines |
| per_rdata | input | DW | Peripheral data word |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Sticky completion interrupt |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| per_ack | output | NCH | Per-channel word acknowledge |
| per_end | output | NCH | Per-channel end-of-block strobe |

## Verification
The timing chain is as follows:
- `bus_req` rises one cycle after an enabled request is seen while waiting.
- A word moves, and `mem_we`, `per_ack` and the address are valid, in every cycle in which the grant and the served request are both high.
- `per_end` follows the last word by exactly one cycle, and `irq` with `busy` low follows one cycle after that.
- A zero-count start shows `irq` in the cycle after the write.

A driver queues each expected address/data pair when it starts a job. A monitor samples at the falling edge, pops one item per write strobe, and then checks the end strobe and interrupt at the next two falling edges. Request rises are counted to check burst against cycle-steal holding.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_WAIT = 3'd1,
        PH_ACQ  = 3'd2,
        PH_MOVE = 3'd3,
        PH_END  = 3'd4
    } phase_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_CLR  = 2'd3;

    localparam int CTRL_GO_BIT    = 0;
    localparam int CTRL_BURST_BIT = 1;
    localparam int CTRL_EN_LSB    = 8;
endpackage

// File: rtl/dma_req_pick.sv
module dma_req_pick #(
    parameter int NCH = 4,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] en,
    output logic           any,
    output logic [CHW-1:0] idx
);
    logic [NCH-1:0] live;

    // Each channel is gated by its own enable bit.
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_mask
            assign live[g] = req[g] & en[g];
        end
    endgenerate

    assign any = |live;

    // Fixed priority: the lowest index wins, so scan from the top down.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (live[i]) idx = CHW'(i);
        end
    end
endmodule

// File: rtl/dma_core.sv
module dma_core
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 16,
    parameter int CHW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    input  logic           pick_any,
    input  logic [CHW-1:0] pick_idx,
    input  logic [NCH-1:0] per_req,
    input  logic [DW-1:0]  per_rdata,
    input  logic           bus_gnt,
    output logic [NCH-1:0] en_mask,
    output logic           bus_req,
    output logic           busy,
    output logic           irq,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [NCH-1:0] per_ack,
    output logic [NCH-1:0] per_end
);
    typedef struct packed {
        phase_e         ph;
        logic [AW-1:0]  addr;
        logic [CW-1:0]  cnt;
        logic [CHW-1:0] ch;
        logic           burst;
        logic [NCH-1:0] en;
        logic           irq;
    } state_t;

    state_t st_q, st_d;
    logic   idle;
    logic   move;
    logic   clr_hit;
    logic   go_zero;

    assign idle    = (st_q.ph == PH_IDLE);
    assign move    = (st_q.ph == PH_MOVE) && bus_gnt && per_req[st_q.ch];
    assign clr_hit = cfg_we && (cfg_sel == SEL_CLR);
    assign go_zero = idle && cfg_we && (cfg_sel == SEL_CTRL)
                     && cfg_wdata[CTRL_GO_BIT] && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (clr_hit) st_d.irq = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (cfg_we) begin
                    case (cfg_sel)
                        SEL_ADDR: st_d.addr = cfg_wdata[AW-1:0];
                        SEL_CNT:  st_d.cnt  = cfg_wdata[CW-1:0];
                        SEL_CTRL: begin
                            st_d.burst = cfg_wdata[CTRL_BURST_BIT];
                            st_d.en    = cfg_wdata[CTRL_EN_LSB +: NCH];
                            if (cfg_wdata[CTRL_GO_BIT]) begin
                                if (st_q.cnt == '0) st_d.irq = 1'b1;
                                else                st_d.ph  = PH_WAIT;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            PH_WAIT: begin
                if (pick_any) begin
                    st_d.ch = pick_idx;
                    st_d.ph = PH_ACQ;
                end
            end
            PH_ACQ: begin
                if (bus_gnt) st_d.ph = PH_MOVE;
            end
            PH_MOVE: begin
                if (move) begin
                    st_d.addr = st_q.addr + AW'(1);
                    st_d.cnt  = st_q.cnt - CW'(1);
                    if (st_q.cnt == CW'(1)) st_d.ph = PH_END;
                    else if (!st_q.burst)   st_d.ph = PH_WAIT;
                end
            end
            PH_END: begin
                st_d.ph  = PH_IDLE;
                st_d.irq = 1'b1;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_mask   = st_q.en;
    assign bus_req   = (st_q.ph == PH_ACQ) || (st_q.ph == PH_MOVE);
    assign busy      = !idle;
    assign irq       = st_q.irq;
    assign mem_we    = move;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = per_rdata;
    assign per_ack   = NCH'(move) << st_q.ch;
    assign per_end   = NCH'(st_q.ph == PH_END) << st_q.ch;

    AST_REQ_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req); // R3
    AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_ack) |-> ((per_ack & st_q.en & per_req) != '0)); // R2
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_ack)); // R2
    AST_END_THEN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_end) |=> (irq && !busy)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (st_q.cnt == CW'($past(st_q.cnt) - CW'(1)))); // R7
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ph == PH_MOVE) && st_q.burst && (st_q.cnt != CW'(1))) |=> bus_req); // R6
    AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        go_zero |=> (!bus_req && irq)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_hit) |=> irq); // R9
    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !st_q.burst) |=> !bus_req); // R10
endmodule

// File: rtl/dma_bus_handover.sv
module dma_bus_handover #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    input  logic [NCH-1:0] per_req,
    input  logic [DW-1:0]  per_rdata,
    input  logic           bus_gnt,
    output logic           bus_req,
    output logic           busy,
    output logic           irq,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic [NCH-1:0] per_ack,
    output logic [NCH-1:0] per_end
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic           pick_any;
    logic [CHW-1:0] pick_idx;
    logic [NCH-1:0] en_mask;

    dma_req_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req (per_req),
        .en  (en_mask),
        .any (pick_any),
        .idx (pick_idx)
    );

    dma_core #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .CHW(CHW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pick_any  (pick_any),
        .pick_idx  (pick_idx),
        .per_req   (per_req),
        .per_rdata (per_rdata),
        .bus_gnt   (bus_gnt),
        .en_mask   (en_mask),
        .bus_req   (bus_req),
        .busy      (busy),
        .irq       (irq),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .per_ack   (per_ack),
        .per_end   (per_end)
    );
endmodule

// File: tb/dma_bus_handover_bench.sv
module dma_bus_handover_bench;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_sel = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [NCH-1:0] per_req = '0;
    logic [DW-1:0]  pdata = '0;
    logic           bus_gnt = 1'b0;
    logic           bus_req, busy, irq, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [NCH-1:0] per_ack, per_end;

    always #5 clk = ~clk;

    dma_bus_handover #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_dma_bus_handover (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .per_req(per_req), .per_rdata(pdata),
        .bus_gnt(bus_gnt), .bus_req(bus_req), .busy(busy), .irq(irq),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .per_ack(per_ack), .per_end(per_end)
    );

    int checks = 0;
    int errors = 0;
    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
    item_t expq[$];
    int  exp_ch = 0;
    int  req_rises = 0;
    int  writes_seen = 0;
    logic req_prev = 1'b0;
    bit  end_due = 0;
    bit  irq_due = 0;
    bit  hold_off = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Peripheral model: a new data word after every acknowledge.
    always @(posedge clk) if (|per_ack) pdata <= pdata + 1'b1;
    // Arbiter model: grants one cycle after the request, unless held off.
    always @(posedge clk) bus_gnt <= bus_req && !hold_off;

    // Monitor: scoreboard pop on every write strobe, then the end sequence.
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req && !req_prev) req_rises++;
            req_prev = bus_req;
            if (end_due) begin
                chk(per_end == NCH'(1 << exp_ch), "R5 per_end one cycle after last word", 32'(per_end), 32'(1 << exp_ch));
                end_due = 0;
                irq_due = 1;
            end else if (irq_due) begin
                chk(irq && !busy, "R5 irq set and busy clear after end", {30'd0, irq, busy}, 32'h2);
                irq_due = 0;
            end
            if (mem_we) begin
                writes_seen++;
                chk(bus_gnt, "R3 write only under grant", 32'(bus_gnt), 32'd1);
                if (expq.size() == 0) begin
                    chk(0, "R7 unexpected write", 32'(mem_addr), 32'hFFFF_FFFF);
                end else begin
                    item_t it;
                    it = expq.pop_front();
                    chk(mem_addr == it.a, "R7 address", 32'(mem_addr), 32'(it.a));
                    chk(mem_wdata == it.d, "R7 data", 32'(mem_wdata), 32'(it.d));
                    chk(per_ack == NCH'(1 << exp_ch), "R2 ack on served channel", 32'(per_ack), 32'(1 << exp_ch));
                    if (expq.size() == 0) end_due = 1;
                end
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Driver: program a job and queue the expected writes.
    task automatic run_job(input logic [AW-1:0] base, input int n, input int ch,
                           input bit burst, input logic [NCH-1:0] en, input logic [DW-1:0] d0);
        cfg_write(2'd0, 32'(base));
        cfg_write(2'd1, 32'(n));
        @(negedge clk);
        pdata = d0;
        for (int i = 0; i < n; i++) begin
            item_t it;
            it.a = base + AW'(i);
            it.d = d0 + DW'(i);
            expq.push_back(it);
        end
        exp_ch = ch;
        req_rises = 0;
        cfg_write(2'd2, (32'(en) << 8) | (32'(burst) << 1) | 32'd1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req && !mem_we && !irq && per_ack == '0 && per_end == '0,
            "R1 reset state", {28'd0, busy, bus_req, mem_we, irq}, 32'd0);

        // Burst job with channels 1 and 2 requesting: channel 1 wins (R2, R6)
        per_req = 4'b0110;
        run_job(16'h0100, 4, 1, 1'b1, 4'b1111, 16'hA000);
        // Writes while busy must be ignored (R4): the scoreboard still expects 0x0100..
        cfg_write(2'd0, 32'h0900);
        cfg_write(2'd1, 32'd9);
        cfg_write(2'd2, 32'h0000_0F03);
        wait_idle();
        per_req = '0;
        chk(expq.size() == 0, "R4 busy writes ignored, all words moved", 32'(expq.size()), 32'd0);
        chk(req_rises == 1, "R6 one bus request per burst block", 32'(req_rises), 32'd1);
        repeat (5) @(negedge clk);
        chk(irq, "R9 irq stays set", 32'(irq), 32'd1);
        chk(!busy, "R4 no restart from busy-time start", 32'(busy), 32'd0);
        cfg_write(2'd3, 32'd0);
        chk(!irq, "R9 irq cleared by write", 32'(irq), 32'd0);

        // Masked channel must not start the bus request (R2)
        per_req = 4'b0001;
        run_job(16'h0200, 2, 3, 1'b1, 4'b1000, 16'h5500);
        repeat (10) @(negedge clk);
        chk(!bus_req && req_rises == 0, "R2 masked request ignored", 32'(req_rises), 32'd0);
        per_req = 4'b1001;
        wait_idle();
        per_req = '0;
        chk(expq.size() == 0, "R2 enabled channel served", 32'(expq.size()), 32'd0);
        cfg_write(2'd3, 32'd0);

        // Cycle-steal job: one bus request per word (R10)
        per_req = 4'b0100;
        run_job(16'h0300, 3, 2, 1'b0, 4'b0100, 16'h1230);
        wait_idle();
        per_req = '0;
        chk(expq.size() == 0, "R10 steal words moved", 32'(expq.size()), 32'd0);
        chk(req_rises == 3, "R10 one bus request per word", 32'(req_rises), 32'd3);
        cfg_write(2'd3, 32'd0);

        // Grant withheld: request held, no writes (R3)
        hold_off = 1;
        per_req = 4'b0001;
        run_job(16'h0400, 2, 0, 1'b1, 4'b0001, 16'h0077);
        repeat (4) @(negedge clk);
        begin
            int w0;
            w0 = writes_seen;
            repeat (8) @(negedge clk);
            chk(bus_req, "R3 request held without grant", 32'(bus_req), 32'd1);
            chk(writes_seen == w0, "R3 no write without grant", 32'(writes_seen - w0), 32'd0);
        end
        hold_off = 0;
        wait_idle();
        per_req = '0;
        chk(expq.size() == 0, "R3 job completes after grant", 32'(expq.size()), 32'd0);
        cfg_write(2'd3, 32'd0);

        // Zero count: immediate end, no bus request (R8)
        req_rises = 0;
        per_req = 4'b0001;
        cfg_write(2'd1, 32'd0);
        cfg_write(2'd2, 32'h0000_0101);
        chk(irq && !busy, "R8 zero count sets irq at once", {30'd0, irq, busy}, 32'h2);
        repeat (6) @(negedge clk);
        chk(req_rises == 0 && writes_seen == 11, "R8 zero count never requests bus",
            32'(req_rises), 32'd0);
        per_req = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule